// File: doc/BRIEF.md
# Asynchronous Memory Strobe Sequencer

This block runs single read and write transfers against an external asynchronous memory, such as an SRAM or a parallel flash, from a synchronous clock domain. The host raises a request carrying an address, byte enables, write data and a direction bit. The sequencer then drives chip enable, byte enables, address and (on writes) the data bus through three timed phases: setup, strobe and hold. Reads and writes each have their own setup, strobe and hold counts. These counts come from configuration inputs and are latched when a request is accepted.

The memory can slow an access down through a ready line. That line is asynchronous and passes through a two-stage synchronizer. It is looked at only in one strobe cycle, the one where exactly two strobe cycles would still follow. While the synchronized ready is low in that cycle, the strobe is held one clock at a time. Read data is captured on the clock edge that ends the strobe. It is returned to the host together with a one-cycle acknowledge when the hold phase completes.

Top module: `async_mem_seq`

## Requirements
- R1: While reset is high, and in idle, mem_ce_n, mem_re_n, mem_we_n and mem_oe_n are 1, mem_be_n is all ones, mem_dq_oe and req_ack are 0, and mem_addr, mem_dq_out and rsp_rdata are 0.
- R2: A request is accepted on a clock edge where req_valid is 1, the sequencer is idle and req_ack is 0. From that edge, mem_ce_n is 0 and mem_be_n (the inverted req_be) and mem_addr hold the request's values for the whole setup, strobe and hold span. The counts are latched at that edge: the read set when req_write is 0, the write set when it is 1.
- R3: The strobe goes low once the setup count of cycles has passed, and it stays low for the strobe count of cycles unless R5 extends it. The hold count of cycles with the strobe high then follows. A programmed count of 0 behaves as 1.
- R4: Only mem_we_n strobes on writes (req_write=1) and only mem_re_n strobes on reads. On writes, mem_dq_oe is 1 and mem_dq_out carries the write data for the whole setup-to-hold span. On reads, mem_dq_oe stays 0.
- R5: mem_rdy passes through two flip-flops, which reset to 1, before use. The synchronized ready is looked at only in the strobe cycle that has exactly two strobe cycles after it. If it is 0 there, that cycle repeats. At any other time, ready has no effect.
- R6: Once the synchronized ready is seen as 1 in that cycle, exactly two more strobe cycles follow. With a strobe count below 3 there is no such cycle, and the strobe has its fixed length whatever mem_rdy does.
- R7: req_ack is 1 for exactly one cycle, starting at the edge where the hold phase ends. mem_ce_n is 1 in that same cycle. A req_valid present during that cycle is not accepted, so the next transfer starts one edge later.
- R8: On reads, rsp_rdata takes mem_dq_in as sampled on the edge that ends the strobe. It holds that value until the next read captures. Writes leave it unchanged.
- R9: mem_oe_n is low exactly when mem_re_n is low on a read. It stays high on writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_rd_setup | input | CNT_W | Read setup cycles |
| cfg_rd_strobe | input | CNT_W | Read strobe cycles |
| cfg_rd_hold | input | CNT_W | Read hold cycles |
| cfg_wr_setup | input | CNT_W | Write setup cycles |
| cfg_wr_strobe | input | CNT_W | Write strobe cycles |
| cfg_wr_hold | input | CNT_W | Write hold cycles |
| req_valid | input | 1 | Host request pending |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Transfer address |
| req_be | input | DATA_W/8 | Active-high byte enables |
| req_wdata | input | DATA_W | Write data |
| req_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Captured read data |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_be_n | output | DATA_W/8 | Byte enables, active low |
| mem_addr | output | ADDR_W | Memory address |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_re_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_out | output | DATA_W | Data driven to memory |
| mem_dq_oe | output | 1 | Data bus drive enable |
| mem_dq_in | input | DATA_W | Data from memory |
| mem_rdy | input | 1 | Asynchronous ready from memory |

## Verification
Transfers are run with short counts (all ones and all zeros), long asymmetric counts, and strobe counts of 2, 3 and 5. These show whether each phase uses its own count and whether a zero count is clamped. Ready is pulled low in three ways: during setup only, across the window cycle, and through a strobe too short to have a window. Only the second should stretch, and the strobe must end exactly two cycles after ready returns. The memory data changes every cycle, so a capture one edge early or late shows up as a wrong value. A host that keeps req_valid high across the acknowledge shows whether the ack cycle is skipped.

// File: rtl/asm_pkg.sv
`timescale 1ns/1ps
package asm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETUP  = 2'd1,
    PH_STROBE = 2'd2,
    PH_HOLD   = 2'd3
  } phase_t;
endpackage

// File: rtl/asm_rdy_sync.sv
`timescale 1ns/1ps
module asm_rdy_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (rst) sr <= RST_VAL;
        else     sr <= d;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) sr <= {STAGES{RST_VAL}};
        else     sr <= {sr[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = sr[STAGES-1];
endmodule

// File: rtl/asm_phase_ctl.sv
`timescale 1ns/1ps
module asm_phase_ctl
  import asm_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] setup_cnt,
  input  logic [CNT_W-1:0] strobe_cnt,
  input  logic [CNT_W-1:0] hold_cnt,
  input  logic             rdy_s,
  output phase_t           phase,
  output phase_t           phase_nx,
  output logic             cap_edge,
  output logic             done_edge
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);
  localparam logic [CNT_W-1:0] TWO = CNT_W'(2);

  logic [CNT_W-1:0] cnt, cnt_nx;
  logic [CNT_W-1:0] strobe_q, hold_q;

  // remaining cycles after the current one; zero count clamps to one cycle
  function automatic logic [CNT_W-1:0] first_rem(input logic [CNT_W-1:0] v);
    return (v == '0) ? '0 : v - ONE;
  endfunction

  always_comb begin
    phase_nx  = phase;
    cnt_nx    = cnt;
    cap_edge  = 1'b0;
    done_edge = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (start) begin
          phase_nx = PH_SETUP;
          cnt_nx   = first_rem(setup_cnt);
        end
      end
      PH_SETUP: begin
        if (cnt == '0) begin
          phase_nx = PH_STROBE;
          cnt_nx   = first_rem(strobe_q);
        end else begin
          cnt_nx = cnt - ONE;
        end
      end
      PH_STROBE: begin
        if (cnt == '0) begin
          phase_nx = PH_HOLD;
          cnt_nx   = first_rem(hold_q);
          cap_edge = 1'b1;
        end else if (cnt == TWO && !rdy_s) begin
          cnt_nx = cnt;
        end else begin
          cnt_nx = cnt - ONE;
        end
      end
      PH_HOLD: begin
        if (cnt == '0) begin
          phase_nx  = PH_IDLE;
          done_edge = 1'b1;
        end else begin
          cnt_nx = cnt - ONE;
        end
      end
      default: phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase    <= PH_IDLE;
      cnt      <= '0;
      strobe_q <= '0;
      hold_q   <= '0;
    end else begin
      phase <= phase_nx;
      cnt   <= cnt_nx;
      if (start && phase == PH_IDLE) begin
        strobe_q <= strobe_cnt;
        hold_q   <= hold_cnt;
      end
    end
  end

  // window cycle with ready low must keep the strobe phase
  assert_stretch_holds_R5: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_STROBE && cnt == TWO && !rdy_s) |=> (phase == PH_STROBE))
    else $error("strobe not extended while ready low");

  // after the window passes with ready high, two more strobe cycles
  assert_two_after_ready_R6: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_STROBE && cnt == TWO && rdy_s) |=> (phase == PH_STROBE) ##1 (phase == PH_STROBE) ##1 (phase == PH_HOLD))
    else $error("strobe did not end two cycles after ready");
endmodule

// File: rtl/async_mem_seq.sv
`timescale 1ns/1ps
module async_mem_seq
  import asm_pkg::*;
#(
  parameter int ADDR_W    = 20,
  parameter int DATA_W    = 16,
  parameter int CNT_W     = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CNT_W-1:0]    cfg_rd_setup,
  input  logic [CNT_W-1:0]    cfg_rd_strobe,
  input  logic [CNT_W-1:0]    cfg_rd_hold,
  input  logic [CNT_W-1:0]    cfg_wr_setup,
  input  logic [CNT_W-1:0]    cfg_wr_strobe,
  input  logic [CNT_W-1:0]    cfg_wr_hold,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [DATA_W/8-1:0] req_be,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                req_ack,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                mem_ce_n,
  output logic [DATA_W/8-1:0] mem_be_n,
  output logic [ADDR_W-1:0]   mem_addr,
  output logic                mem_oe_n,
  output logic                mem_re_n,
  output logic                mem_we_n,
  output logic [DATA_W-1:0]   mem_dq_out,
  output logic                mem_dq_oe,
  input  logic [DATA_W-1:0]   mem_dq_in,
  input  logic                mem_rdy
);
  localparam int BE_W = DATA_W / 8;

  phase_t           phase, phase_nx;
  logic             start, cap_edge, done_edge, rdy_s;
  logic             wr_q, wr_eff, strobe_nx, busy_nx;
  logic [BE_W-1:0]  be_q, be_eff;
  logic [CNT_W-1:0] sel_setup, sel_strobe, sel_hold;

  assign start      = req_valid && (phase == PH_IDLE) && !req_ack;
  assign sel_setup  = req_write ? cfg_wr_setup  : cfg_rd_setup;
  assign sel_strobe = req_write ? cfg_wr_strobe : cfg_rd_strobe;
  assign sel_hold   = req_write ? cfg_wr_hold   : cfg_rd_hold;
  assign wr_eff     = start ? req_write : wr_q;
  assign be_eff     = start ? req_be    : be_q;
  assign strobe_nx  = (phase_nx == PH_STROBE);
  assign busy_nx    = (phase_nx != PH_IDLE);

  asm_rdy_sync #(.STAGES(SYNC_DEPTH), .RST_VAL(1'b1)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (mem_rdy),
    .q   (rdy_s)
  );

  asm_phase_ctl #(.CNT_W(CNT_W)) u_ctl (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .setup_cnt  (sel_setup),
    .strobe_cnt (sel_strobe),
    .hold_cnt   (sel_hold),
    .rdy_s      (rdy_s),
    .phase      (phase),
    .phase_nx   (phase_nx),
    .cap_edge   (cap_edge),
    .done_edge  (done_edge)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q       <= 1'b0;
      be_q       <= '0;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      mem_ce_n   <= 1'b1;
      mem_be_n   <= '1;
      mem_re_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_oe_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      req_ack    <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      if (start) begin
        wr_q       <= req_write;
        be_q       <= req_be;
        mem_addr   <= req_addr;
        mem_dq_out <= req_wdata;
      end
      mem_ce_n  <= !busy_nx;
      mem_be_n  <= busy_nx ? ~be_eff : '1;
      mem_re_n  <= !(strobe_nx && !wr_eff);
      mem_oe_n  <= !(strobe_nx && !wr_eff);
      mem_we_n  <= !(strobe_nx && wr_eff);
      mem_dq_oe <= busy_nx && wr_eff;
      req_ack   <= done_edge;
      if (cap_edge && !wr_q) rsp_rdata <= mem_dq_in;
    end
  end

  assert_ack_idle_R7: assert property (@(posedge clk) disable iff (rst)
    req_ack |-> mem_ce_n)
    else $error("ack with chip enable active");

  assert_ack_single_R7: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> !req_ack)
    else $error("ack longer than one cycle");

  assert_strobe_in_ce_R2: assert property (@(posedge clk) disable iff (rst)
    (!mem_re_n || !mem_we_n) |-> !mem_ce_n)
    else $error("strobe outside chip enable");

  assert_one_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    !(!mem_re_n && !mem_we_n))
    else $error("both strobes low");

  assert_wdata_driven_R4: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> mem_dq_oe)
    else $error("write strobe without data drive");

  assert_oe_read_only_R9: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> !mem_dq_oe)
    else $error("output enable during write");
endmodule

// File: tb/async_mem_seq_tb.sv
`timescale 1ns/1ps
module async_mem_seq_tb_top;
  localparam int ADDR_W = 20;
  localparam int DATA_W = 16;
  localparam int CNT_W  = 4;
  localparam int BE_W   = DATA_W / 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic [CNT_W-1:0] rd_s = 1, rd_t = 1, rd_h = 1, wr_s = 1, wr_t = 1, wr_h = 1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [BE_W-1:0]   req_be = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic req_ack, mem_ce_n, mem_oe_n, mem_re_n, mem_we_n, mem_dq_oe;
  logic [DATA_W-1:0] rsp_rdata, mem_dq_out;
  logic [DATA_W-1:0] mem_dq_in = '0;
  logic [BE_W-1:0]   mem_be_n;
  logic [ADDR_W-1:0] mem_addr;
  logic mem_rdy = 1'b1;

  async_mem_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst),
    .cfg_rd_setup(rd_s), .cfg_rd_strobe(rd_t), .cfg_rd_hold(rd_h),
    .cfg_wr_setup(wr_s), .cfg_wr_strobe(wr_t), .cfg_wr_hold(wr_h),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .req_ack(req_ack),
    .rsp_rdata(rsp_rdata), .mem_ce_n(mem_ce_n), .mem_be_n(mem_be_n),
    .mem_addr(mem_addr), .mem_oe_n(mem_oe_n), .mem_re_n(mem_re_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in), .mem_rdy(mem_rdy)
  );

  int cyc = 0, n_cmp = 0, n_bad = 0;
  int lo_a = -1, lo_b = -1;
  bit seen_edge = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    seen_edge <= 1'b1;
  end

  // memory side: data changes every cycle, ready low in a scheduled window
  always @(negedge clk) begin
    mem_dq_in = DATA_W'(cyc * 37 + 16'h1234);
    mem_rdy   = !(cyc >= lo_a && cyc < lo_b);
  end

  // behavioural reference: phase 0 idle, 1 setup, 2 strobe, 3 hold
  int m_ph = 0, m_left = 0, m_t = 1, m_h = 1;
  bit m_wr = 0, m_ack = 0, m_r1 = 1, m_r2 = 1;
  logic [ADDR_W-1:0] m_addr = '0;
  logic [BE_W-1:0]   m_be = '0;
  logic [DATA_W-1:0] m_wd = '0, m_rd = '0;

  function automatic int atleast1(input logic [CNT_W-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  always @(posedge clk) begin
    bit rdy_seen, ack_now;
    if (rst) begin
      m_ph = 0; m_left = 0; m_wr = 0; m_ack = 0; m_r1 = 1; m_r2 = 1;
      m_addr = '0; m_be = '0; m_wd = '0; m_rd = '0;
    end else begin
      rdy_seen = m_r2;
      m_r2 = m_r1;
      m_r1 = mem_rdy;
      ack_now = 0;
      case (m_ph)
        0: if (req_valid && !m_ack) begin
             m_wr = req_write; m_addr = req_addr; m_be = req_be; m_wd = req_wdata;
             m_left = atleast1(req_write ? wr_s : rd_s);
             m_t    = atleast1(req_write ? wr_t : rd_t);
             m_h    = atleast1(req_write ? wr_h : rd_h);
             m_ph   = 1;
           end
        1: begin
             m_left--;
             if (m_left == 0) begin m_ph = 2; m_left = m_t; end
           end
        2: if (!(m_left == 3 && !rdy_seen)) begin
             m_left--;
             if (m_left == 0) begin
               if (!m_wr) m_rd = mem_dq_in;
               m_ph = 3; m_left = m_h;
             end
           end
        default: begin
             m_left--;
             if (m_left == 0) begin m_ph = 0; ack_now = 1; end
           end
      endcase
      m_ack = ack_now;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst && seen_edge) begin
      chk("R1 ce_n", 32'(mem_ce_n), 1);
      chk("R1 strobes", {29'd0, mem_re_n, mem_we_n, mem_oe_n}, 32'd7);
      chk("R1 be_n", 32'(mem_be_n), 32'((1 << BE_W) - 1));
      chk("R1 dq_oe/ack", {30'd0, mem_dq_oe, req_ack}, 0);
      chk("R1 addr/data", 32'(mem_addr) | 32'(mem_dq_out) | 32'(rsp_rdata), 0);
    end else if (!rst) begin
      chk("R2 ce_n", 32'(mem_ce_n), 32'(m_ph == 0));
      chk("R2 addr", 32'(mem_addr), 32'(m_addr));
      chk("R2 be_n", 32'(mem_be_n), (m_ph == 0) ? 32'((1 << BE_W) - 1) : 32'(BE_W'(~m_be)));
      chk("R3/R5/R6 re_n", 32'(mem_re_n), 32'(!(m_ph == 2 && !m_wr)));
      chk("R3/R4 we_n", 32'(mem_we_n), 32'(!(m_ph == 2 && m_wr)));
      chk("R9 oe_n", 32'(mem_oe_n), 32'(!(m_ph == 2 && !m_wr)));
      chk("R4 dq_oe", 32'(mem_dq_oe), 32'(m_ph != 0 && m_wr));
      chk("R4 dq_out", 32'(mem_dq_out), 32'(m_wd));
      chk("R7 ack", 32'(req_ack), 32'(m_ack));
      chk("R8 rdata", 32'(rsp_rdata), 32'(m_rd));
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic xfer(input bit wr, input logic [ADDR_W-1:0] a,
                      input logic [BE_W-1:0] be, input logic [DATA_W-1:0] wd);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_be = be; req_wdata = wd;
    do @(negedge clk); while (!req_ack);
    req_valid = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_rd(input int s, input int t, input int h);
    rd_s = CNT_W'(s); rd_t = CNT_W'(t); rd_h = CNT_W'(h);
  endtask

  task automatic set_wr(input int s, input int t, input int h);
    wr_s = CNT_W'(s); wr_t = CNT_W'(t); wr_h = CNT_W'(h);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    repeat (2) @(negedge clk);
    // R2/R3/R8: plain read with distinct phase lengths
    set_rd(2, 4, 3);
    xfer(0, 20'hA5A5A, 2'b11, 16'h0);
    // R4: short write
    set_wr(1, 1, 1);
    xfer(1, 20'h00123, 2'b01, 16'hBEEF);
    // R3: zero counts clamp to one
    set_rd(0, 0, 0); set_wr(0, 0, 0);
    xfer(0, 20'h0F0F0, 2'b10, 16'h0);
    xfer(1, 20'h70001, 2'b11, 16'h5A5A);
    // R5: ready low only during setup is ignored
    set_rd(6, 6, 1);
    lo_a = cyc + 2; lo_b = cyc + 5;
    xfer(0, 20'h11111, 2'b11, 16'h0);
    // R5/R6: ready low across window stretches the read strobe
    set_rd(2, 5, 2);
    lo_a = cyc + 3; lo_b = cyc + 11;
    xfer(0, 20'h22222, 2'b01, 16'h0);
    // R5/R6: window on first strobe cycle with strobe count 3, write
    set_wr(1, 3, 2);
    lo_a = cyc; lo_b = cyc + 9;
    xfer(1, 20'h33333, 2'b10, 16'hC0DE);
    // R6: strobe count 2 has no window
    set_rd(1, 2, 1);
    lo_a = cyc; lo_b = cyc + 20;
    xfer(0, 20'h44444, 2'b11, 16'h0);
    lo_a = -1; lo_b = -1;
    repeat (3) @(negedge clk);
    // R7: request held through ack is not taken in the ack cycle
    set_rd(1, 2, 1); set_wr(2, 1, 2);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = 20'h55555; req_be = 2'b11;
    do @(negedge clk); while (!req_ack);
    req_write = 1; req_addr = 20'h66666; req_wdata = 16'h1357; req_be = 2'b01;
    do @(negedge clk); while (!req_ack);
    req_valid = 0;
    repeat (4) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule